// File: doc/BRIEF.md
# Seconds-Counter Real-Time Clock with Alarm

This block is a register-mapped real-time clock. It keeps a running count of seconds and advances it from a synchronous 32.768 kHz tick enable, which a prescaler divides down to one step per second. Software reads the current count through a data register. It sets the count through a separate load register, which also restarts the prescaler. A control bit starts and stops counting.

A match register holds an alarm time. The alarm event is set in the cycle in which the counter takes on a value equal to the match value. This can happen through a normal one-second step or through a load. The event is latched in a raw status bit and gated by a mask bit into a masked status bit. The masked status drives the interrupt output. Software removes a pending alarm by writing a one to the clear register.

The block sits on a simple two-phase register bus with a setup cycle and an access cycle. A write takes effect at the clock edge that ends the access cycle. Read data is a combinational decode of the address.

Top module: `rtc_sec_alarm`

## Requirements
- R1: After reset, every readable register reads zero: data 0x00, match 0x04, control 0x0C, mask 0x10, raw status 0x14 and masked status 0x18. The interrupt output is low.
- R2: A write to offset 0x08 sets the count to the written value, and offset 0x00 returns it from the next cycle. The write also restarts the prescaler, so the first step after a load comes on the 2^PRESC_W-th enabled tick.
- R3: While control bit 26 is 1, the count rises by one on every 2^PRESC_W-th cycle with the tick input high. The default PRESC_W of 15 gives 32768 ticks per second.
- R4: While control bit 26 is 0, the tick input is ignored, and both the count and the prescaler phase hold. Only bit 26 of the control register is stored. Its other bits read 0.
- R5: Offset 0x04 is a full-width read/write match register.
- R6: Raw status bit 0 at offset 0x14 becomes 1 in the cycle in which the count takes a new value equal to the match register, through either a step or a load. It then stays 1 until it is cleared.
- R7: A write to offset 0x1C with bit 0 equal to 1 clears raw status bit 0. A write with bit 0 equal to 0 has no effect. When a set and a clear fall in the same cycle, the set wins.
- R8: Mask bit 0 at offset 0x10 is read/write. Masked status bit 0 at offset 0x18 equals raw bit 0 AND mask bit 0. The interrupt output is the OR of the masked status bits.
- R9: Offsets 0x08 and 0x1C, and every offset from 0x20 up, read as zero. Writes to 0x00, 0x14, 0x18 and to undefined offsets change nothing.
- R10: The count wraps from all ones to zero on a step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | 1 | 32.768 kHz tick, one-cycle synchronous enable |
| psel_i | input | 1 | Bus select |
| penable_i | input | 1 | Bus access phase |
| pwrite_i | input | 1 | Bus write when 1, read when 0 |
| paddr_i | input | ADDR_W (12) | Byte address |
| pwdata_i | input | DATA_W (32) | Write data |
| prdata_o | output | DATA_W (32) | Read data, decoded from paddr_i |
| irq_o | output | 1 | Alarm interrupt |

## Verification
The hardest situation to reach is a write-one clear of the alarm that lands in the same cycle as the one-second step that makes the count equal the match value. The stimulus holds the tick high and loads the count one below the match, which restarts the prescaler at a known phase. It then idles a counted number of cycles so that the clear's access edge falls on the sixteenth tick of the shortened prescaler used by the bench. The other hard cases are placed by the same counting from a load: the step count at the exact edge, and the wrap from all ones. Randomly interleaved bus operations and random ticks are then checked against a cycle model of the requirements.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    localparam int CTRL_EN_BIT = 26;
    localparam int ALARM_BIT   = 0;
    localparam int SEL_W       = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_DATA  = 3'd0,
        SEL_MATCH = 3'd1,
        SEL_LOAD  = 3'd2,
        SEL_CTRL  = 3'd3,
        SEL_MASK  = 3'd4,
        SEL_RAW   = 3'd5,
        SEL_MSK   = 3'd6,
        SEL_CLR   = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic     hit;
        reg_sel_e sel;
    } reg_dec_t;

    function automatic reg_dec_t decode_reg(input logic upper_zero,
                                            input logic [SEL_W-1:0] widx);
        reg_dec_t d;
        d.hit = upper_zero;
        d.sel = reg_sel_e'(widx);
        return d;
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
    parameter int PRESC_W = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic tick_i,
    input  logic en_i,
    input  logic clr_i,
    output logic sec_o
);
    logic [PRESC_W-1:0] pre_q;
    logic               adv;

    assign adv   = tick_i & en_i;
    assign sec_o = adv & (&pre_q) & ~clr_i;

    always_ff @(posedge clk) begin
        if (rst || clr_i) begin
            pre_q <= '0;
        end else if (adv) begin
            pre_q <= pre_q + PRESC_W'(1);
        end
    end

    assert_pre_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!en_i && !clr_i) |=> $stable(pre_q));

    assert_pre_restart_R3: assert property (@(posedge clk) disable iff (rst)
        sec_o |=> (pre_q == '0));

endmodule

// File: rtl/rtc_counter.sv
module rtc_counter #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             sec_i,
    input  logic [CNT_W-1:0] match_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             hit_o
);
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_d;
    logic             upd;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (sec_i) begin
            cnt_d = cnt_q + CNT_W'(1);
        end
    end

    assign upd   = load_i | sec_i;
    assign hit_o = upd & (cnt_d == match_i);
    assign cnt_o = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assert_cnt_hold_R4: assert property (@(posedge clk) disable iff (rst)
        (!load_i && !sec_i) |=> $stable(cnt_q));

    assert_cnt_step_R10: assert property (@(posedge clk) disable iff (rst)
        (sec_i && !load_i) |=> (cnt_q == CNT_W'($past(cnt_q) + CNT_W'(1))));

    assert_cnt_load_R2: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (cnt_q == $past(load_val_i)));

endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    input  logic mask_we_i,
    input  logic mask_val_i,
    output logic raw_o,
    output logic mask_o,
    output logic irq_o
);
    logic raw_q;
    logic mask_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q  <= 1'b0;
            mask_q <= 1'b0;
        end else begin
            if (set_i) begin
                raw_q <= 1'b1;
            end else if (clr_i) begin
                raw_q <= 1'b0;
            end
            if (mask_we_i) begin
                mask_q <= mask_val_i;
            end
        end
    end

    assign raw_o  = raw_q;
    assign mask_o = mask_q;
    assign irq_o  = raw_q & mask_q;

    assert_raw_sticky_R6: assert property (@(posedge clk) disable iff (rst)
        (raw_q && !clr_i) |=> raw_q);

    assert_raw_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !set_i) |=> !raw_q);

    assert_raw_set_R6: assert property (@(posedge clk) disable iff (rst)
        set_i |=> raw_q);

endmodule

// File: rtl/rtc_sec_alarm.sv
module rtc_sec_alarm
    import rtc_pkg::*;
#(
    parameter int ADDR_W  = 12,
    parameter int DATA_W  = 32,
    parameter int PRESC_W = 15
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick_i,
    input  logic              psel_i,
    input  logic              penable_i,
    input  logic              pwrite_i,
    input  logic [ADDR_W-1:0] paddr_i,
    input  logic [DATA_W-1:0] pwdata_i,
    output logic [DATA_W-1:0] prdata_o,
    output logic              irq_o
);
    localparam int IDX_LO = 2;
    localparam int IDX_HI = IDX_LO + SEL_W - 1;

    reg_dec_t          dec;
    logic              wr;
    logic              wr_match, wr_load, wr_ctrl, wr_mask, wr_clr;
    logic [DATA_W-1:0] match_q;
    logic              en_q;
    logic [DATA_W-1:0] cnt;
    logic              sec;
    logic              hit;
    logic              raw, mask;
    logic              unused_addr_lsb;

    assign unused_addr_lsb = ^paddr_i[IDX_LO-1:0];

    assign dec = decode_reg(paddr_i[ADDR_W-1:IDX_HI+1] == '0,
                            paddr_i[IDX_HI:IDX_LO]);
    assign wr  = psel_i & penable_i & pwrite_i & dec.hit;

    assign wr_match = wr & (dec.sel == SEL_MATCH);
    assign wr_load  = wr & (dec.sel == SEL_LOAD);
    assign wr_ctrl  = wr & (dec.sel == SEL_CTRL);
    assign wr_mask  = wr & (dec.sel == SEL_MASK);
    assign wr_clr   = wr & (dec.sel == SEL_CLR) & pwdata_i[ALARM_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            match_q <= '0;
            en_q    <= 1'b0;
        end else begin
            if (wr_match) begin
                match_q <= pwdata_i;
            end
            if (wr_ctrl) begin
                en_q <= pwdata_i[CTRL_EN_BIT];
            end
        end
    end

    rtc_prescaler #(.PRESC_W(PRESC_W)) presc_i (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick_i),
        .en_i   (en_q),
        .clr_i  (wr_load),
        .sec_o  (sec)
    );

    rtc_counter #(.CNT_W(DATA_W)) cnt_i (
        .clk        (clk),
        .rst        (rst),
        .load_i     (wr_load),
        .load_val_i (pwdata_i),
        .sec_i      (sec),
        .match_i    (match_q),
        .cnt_o      (cnt),
        .hit_o      (hit)
    );

    rtc_alarm_irq irq_i (
        .clk        (clk),
        .rst        (rst),
        .set_i      (hit),
        .clr_i      (wr_clr),
        .mask_we_i  (wr_mask),
        .mask_val_i (pwdata_i[ALARM_BIT]),
        .raw_o      (raw),
        .mask_o     (mask),
        .irq_o      (irq_o)
    );

    always_comb begin
        prdata_o = '0;
        if (dec.hit) begin
            case (dec.sel)
                SEL_DATA:  prdata_o = cnt;
                SEL_MATCH: prdata_o = match_q;
                SEL_CTRL:  prdata_o[CTRL_EN_BIT] = en_q;
                SEL_MASK:  prdata_o[ALARM_BIT] = mask;
                SEL_RAW:   prdata_o[ALARM_BIT] = raw;
                SEL_MSK:   prdata_o[ALARM_BIT] = raw & mask;
                default:   prdata_o = '0;
            endcase
        end
    end

    assert_irq_needs_mask_R8: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> mask);

    assert_no_step_when_off_R4: assert property (@(posedge clk) disable iff (rst)
        !en_q |-> !sec);

endmodule

// File: tb/rtc_sec_alarm_tb_top.sv
module rtc_sec_alarm_tb_top;
    localparam int ADDR_W  = 12;
    localparam int DATA_W  = 32;
    localparam int PRESC_W = 4;
    localparam logic [31:0] EN_WORD = 32'h0400_0000;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              tick = 1'b0;
    logic              psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [ADDR_W-1:0] paddr = '0;
    logic [DATA_W-1:0] pwdata = '0;
    logic [DATA_W-1:0] prdata;
    logic              irq;

    logic tick_rand  = 1'b0;
    logic tick_level = 1'b0;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    rtc_sec_alarm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PRESC_W(PRESC_W)) dut_i (
        .clk(clk), .rst(rst), .tick_i(tick), .psel_i(psel), .penable_i(penable),
        .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata),
        .prdata_o(prdata), .irq_o(irq)
    );

    always @(negedge clk) begin
        tick <= tick_rand ? 1'($urandom % 2) : tick_level;
    end

    // Cycle model built from the requirements
    logic [PRESC_W-1:0] m_pre;
    logic [DATA_W-1:0]  m_cnt, m_match;
    logic               m_en, m_mask, m_raw;

    always @(posedge clk) begin
        logic wr, ld, clr, inc, chg;
        logic [DATA_W-1:0] nxt;
        if (rst) begin
            m_pre <= '0; m_cnt <= '0; m_match <= '0;
            m_en <= 1'b0; m_mask <= 1'b0; m_raw <= 1'b0;
        end else begin
            wr  = psel && penable && pwrite && (paddr[ADDR_W-1:5] == '0);
            ld  = wr && (paddr[4:2] == 3'd2);
            clr = wr && (paddr[4:2] == 3'd7) && pwdata[0];
            inc = !ld && tick && m_en && (m_pre == '1);
            nxt = ld ? pwdata : (inc ? m_cnt + 1 : m_cnt);
            chg = ld || inc;
            if (ld) m_pre <= '0;
            else if (tick && m_en) m_pre <= m_pre + 1'b1;
            m_cnt <= nxt;
            if (chg && nxt == m_match) m_raw <= 1'b1;
            else if (clr) m_raw <= 1'b0;
            if (wr && paddr[4:2] == 3'd1) m_match <= pwdata;
            if (wr && paddr[4:2] == 3'd3) m_en <= pwdata[26];
            if (wr && paddr[4:2] == 3'd4) m_mask <= pwdata[0];
        end
    end

    function automatic logic [31:0] model_read(input logic [ADDR_W-1:0] a);
        if (a[ADDR_W-1:5] != '0) return 32'h0;
        case (a[4:2])
            3'd0: return m_cnt;
            3'd1: return m_match;
            3'd3: return m_en ? EN_WORD : 32'h0;
            3'd4: return {31'h0, m_mask};
            3'd5: return {31'h0, m_raw};
            3'd6: return {31'h0, m_raw & m_mask};
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input logic ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [ADDR_W-1:0] a, input logic [31:0] d);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
        @(negedge clk); penable = 1'b1;
        @(negedge clk); psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    // Samples after the setup edge; expected value given explicitly
    task automatic rd_exp(input logic [ADDR_W-1:0] a, input logic [31:0] exp,
                          input string req);
        psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
        @(negedge clk); penable = 1'b1; #1;
        chk(prdata == exp, req, prdata, exp);
        @(negedge clk); psel = 1'b0; penable = 1'b0;
    endtask

    task automatic rd_model(input logic [ADDR_W-1:0] a, input string req);
        logic [31:0] e;
        psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
        @(negedge clk); penable = 1'b1; #1;
        e = model_read(a);
        chk(prdata == e, req, prdata, e);
        chk(irq == (m_raw & m_mask), "R8 irq", {31'h0, irq}, {31'h0, m_raw & m_mask});
        @(negedge clk); psel = 1'b0; penable = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int i = 0; i < 7; i++) rd_exp(ADDR_W'(i * 4), 32'h0, "R1 reset read");
        chk(irq == 1'b0, "R1 irq", {31'h0, irq}, 32'h0);

        // R4 disabled: ticks ignored
        tick_level = 1'b1;
        wr_reg(12'h008, 32'd50);
        idle(40);
        rd_exp(12'h000, 32'd50, "R4 count frozen");
        wr_reg(12'h00C, 32'hFFFF_FFFF);
        rd_exp(12'h00C, EN_WORD, "R4 only enable bit stored");

        // R2/R3 load restarts prescaler, step on 16th tick
        wr_reg(12'h008, 32'd100);
        idle(14);
        rd_exp(12'h000, 32'd100, "R2 before first step");
        rd_exp(12'h000, 32'd101, "R3 first step");

        // R10 wrap
        wr_reg(12'h008, 32'hFFFF_FFFF);
        idle(14);
        rd_exp(12'h000, 32'hFFFF_FFFF, "R10 before wrap");
        rd_exp(12'h000, 32'h0, "R10 wrap to zero");

        // R5 match read/write
        wr_reg(12'h004, 32'hA5C3_0F01);
        rd_exp(12'h004, 32'hA5C3_0F01, "R5 match readback");

        // R6 set by load to match value, sticky
        wr_reg(12'h004, 32'd500);
        wr_reg(12'h008, 32'd500);
        rd_exp(12'h014, 32'h1, "R6 set by load");
        idle(40);
        rd_exp(12'h014, 32'h1, "R6 sticky");

        // R8 mask gating
        rd_exp(12'h018, 32'h0, "R8 masked off");
        chk(irq == 1'b0, "R8 irq low when masked", {31'h0, irq}, 32'h0);
        wr_reg(12'h010, 32'h1);
        rd_exp(12'h018, 32'h1, "R8 masked on");
        chk(irq == 1'b1, "R8 irq high", {31'h0, irq}, 32'h1);

        // R7 clear with 0 ignored; R9 write to status ignored
        wr_reg(12'h01C, 32'hFFFF_FFFE);
        rd_exp(12'h014, 32'h1, "R7 zero write no effect");
        wr_reg(12'h014, 32'h0);
        wr_reg(12'h018, 32'h0);
        rd_exp(12'h014, 32'h1, "R9 status write ignored");
        wr_reg(12'h020, 32'hFFFF_FFFF);
        wr_reg(12'h400, 32'hFFFF_FFFF);
        rd_exp(12'h020, 32'h0, "R9 undefined reads zero");
        rd_exp(12'h008, 32'h0, "R9 load reads zero");
        rd_exp(12'h01C, 32'h0, "R9 clear reads zero");
        rd_exp(12'h004, 32'd500, "R9 match untouched by undefined write");
        wr_reg(12'h01C, 32'h1);
        rd_exp(12'h014, 32'h0, "R7 clear");

        // R7 set and clear in the same cycle: set wins
        wr_reg(12'h004, 32'd201);
        wr_reg(12'h008, 32'd200);
        idle(14);
        wr_reg(12'h01C, 32'h1);
        rd_exp(12'h014, 32'h1, "R7 set wins collision");
        wr_reg(12'h01C, 32'h1);
        rd_exp(12'h014, 32'h0, "R7 clear after collision");

        // Random phase against the model
        tick_rand = 1'b1;
        for (int n = 0; n < 600; n++) begin
            int op;
            int idx;
            logic [31:0] d;
            op  = $urandom % 3;
            idx = $urandom % 10;
            d   = $urandom;
            if (op == 0) begin
                case (idx)
                    1: d = m_cnt + ($urandom % 3);
                    2: d = ($urandom % 2) ? m_match - ($urandom % 2) : d;
                    3: d = ($urandom % 5 != 0) ? (d | EN_WORD) : d;
                    default: ;
                endcase
                wr_reg(ADDR_W'(idx * 4), d);
            end else if (op == 1) begin
                rd_model(ADDR_W'(idx * 4), "R2 R3 R6 R7 R8 R9 random read");
            end else begin
                idle($urandom % 20);
                rd_model(12'h000, "R3 random count");
            end
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule